// File: doc/BRIEF.md
# Stepped Frequency Sweep Controller

This block drives a signal source through a repeating stepped sweep between two frequencies held in kilohertz. An operator sets it up with a single advance button. The first press leaves idle. The next three presses capture, in turn, the start frequency, the end frequency and a step-count choice. The last of these presses also starts a multi-cycle integer division that turns the span into a step size. When the division finishes, the block enters its running phase. From then on it presents one frequency point per dwell tick, together with a one-cycle load request for the synthesizer loader.

Each sweep has N steps and N+1 points. Points 0 to N-1 sit at the lower bound plus k times the step size, and point N sits exactly on the upper bound. After point N the next tick wraps back to the lower bound and raises a sweep-start marker, which can trigger an oscilloscope. If the end frequency was set below the start frequency, the two bounds are exchanged. An abort input, typically a mode-button press, returns the block to idle from any phase.

Top module: `sweep_scan_ctrl`

## Requirements
- R1: After reset, phase is idle (0), freq_khz is 0, and load_req and sweep_mark are 0.
- R2: Each scan pulse moves the phase from idle (0) to start (1), then to end (2), then to steps (3), then to dividing (4). The phase leaves dividing only for running (5). Scan pulses are ignored while dividing or running.
- R3: start_khz is captured only by the scan pulse that leaves the start phase, stop_khz only by the scan pulse that leaves the end phase, and steps_sel only by the scan pulse that leaves the steps phase. Changes at any other time have no effect on the sweep.
- R4: steps_sel selects the step count N: 0 gives 10, 1 gives 20, 2 gives 50, 3 gives 100, 4 gives 200, and 5, 6 and 7 give 500. A full sweep therefore takes N+1 dwell ticks from one marker to the next.
- R5: With lo and hi the sweep bounds, the step size is floor((hi - lo) / N). Point k for k < N is lo + k * step, and point N is exactly hi.
- R6: If the captured end frequency is below the captured start frequency, lo is the end value and hi is the start value.
- R7: The first point (lo) is presented with load_req high exactly FW+1 clock edges after the edge that samples the scan pulse leaving the steps phase. FW is 18 by default.
- R8: In the running phase, a dwell tick advances one point, and freq_khz and load_req (a one-cycle pulse) change at the next clock edge. Dwell ticks in any other phase are ignored and produce no load_req.
- R9: sweep_mark is a one-cycle pulse, always with load_req, on the first point after entering the running phase and on every wrap from hi back to lo.
- R10: Abort returns the phase to idle at the next edge from any phase, including dividing and running. It suppresses any load_req due in that cycle and leaves freq_khz unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_khz | input | FW | Start frequency in kHz |
| stop_khz | input | FW | End frequency in kHz |
| steps_sel | input | 3 | Step-count choice (R4 encoding) |
| scan | input | 1 | One-cycle advance pulse |
| abort | input | 1 | Return to idle |
| dwell_tick | input | 1 | One-cycle pulse per dwell period |
| freq_khz | output | FW | Current sweep frequency in kHz |
| load_req | output | 1 | One-cycle request to load freq_khz |
| sweep_mark | output | 1 | One-cycle marker at the first point of each sweep |
| phase | output | 3 | Phase code: 0 idle, 1 start, 2 end, 3 steps, 4 dividing, 5 running |

## Verification
A scan pulse, a dwell tick or an abort is sampled at one edge, and phase, freq_khz, load_req and sweep_mark all reflect it at that same edge. The one exception is the entry to running, which appears FW+1 edges after the final setup pulse. The bench drives inputs on the falling edge. Its behavioural model advances on the rising edge using a countdown for the divide wait, and every output is compared against the model two time units after each rising edge. Directed checks sample on the falling edge after a stimulus, which is the first point where the effect is due. For the divide wait they count those falling edges until load_req appears.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_END   = 3'd2,
    PH_STEPS = 3'd3,
    PH_DIV   = 3'd4,
    PH_RUN   = 3'd5
  } phase_e;

  // Step-count menu; selector values above the last entry use the largest count.
  function automatic int unsigned steps_for(input logic [2:0] sel);
    case (sel)
      3'd0:    steps_for = 10;
      3'd1:    steps_for = 20;
      3'd2:    steps_for = 50;
      3'd3:    steps_for = 100;
      3'd4:    steps_for = 200;
      default: steps_for = 500;
    endcase
  endfunction

endpackage

// File: rtl/sweep_divider.sv
module sweep_divider #(
  parameter int NW = 18,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quotient
);
  localparam int CNTW = $clog2(NW + 1);
  localparam int PW   = NW + DW;

  logic [NW-1:0]   quo;
  logic [DW:0]     rem;
  logic [DW:0]     trial;
  logic [CNTW-1:0] cnt;
  logic            busy;
  logic [NW-1:0]   dvd_r;
  logic [DW-1:0]   dvs_r;

  // Restoring division, one quotient bit per cycle.
  always_comb trial = {rem[DW-1:0], quo[NW-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      quo   <= '0;
      rem   <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      dvd_r <= '0;
      dvs_r <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        quo   <= dividend;
        rem   <= '0;
        cnt   <= CNTW'(NW);
        busy  <= 1'b1;
        dvd_r <= dividend;
        dvs_r <= divisor;
      end else if (busy) begin
        if (trial >= {1'b0, dvs_r}) begin
          rem <= trial - {1'b0, dvs_r};
          quo <= {quo[NW-2:0], 1'b1};
        end else begin
          rem <= trial;
          quo <= {quo[NW-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CNTW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo;

  logic [PW-1:0] prod;
  always_comb prod = {{DW{1'b0}}, quo} * {{NW{1'b0}}, dvs_r};

  // R5: the finished quotient is the floor of the captured span over the count
  assert_quotient_floor_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (prod <= {{DW{1'b0}}, dvd_r}) &&
             (({{DW{1'b0}}, dvd_r} - prod) < {{NW{1'b0}}, dvs_r}));

endmodule

// File: rtl/sweep_phase_fsm.sv
module sweep_phase_fsm
  import sweep_pkg::*;
#(
  parameter int FW = 18,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scan,
  input  logic          abort,
  input  logic [FW-1:0] start_khz,
  input  logic [FW-1:0] stop_khz,
  input  logic [2:0]    steps_sel,
  input  logic          div_done,
  output phase_e        phase_o,
  output logic          div_go,
  output logic          run_go,
  output logic [FW-1:0] span_o,
  output logic [CW-1:0] count_o,
  output logic [FW-1:0] lo_o,
  output logic [FW-1:0] hi_o,
  output logic [CW-1:0] n_o
);
  phase_e        phase;
  logic [FW-1:0] a_r, b_r;
  logic          swapped;

  always_comb begin
    swapped = (b_r < a_r);
    span_o  = swapped ? (a_r - b_r) : (b_r - a_r);
    count_o = CW'(steps_for(steps_sel));
    div_go  = (phase == PH_STEPS) && scan && !abort;
    run_go  = (phase == PH_DIV) && div_done && !abort;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      a_r   <= '0;
      b_r   <= '0;
      lo_o  <= '0;
      hi_o  <= '0;
      n_o   <= '0;
    end else if (abort) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE:  if (scan) phase <= PH_START;
        PH_START: if (scan) begin a_r <= start_khz; phase <= PH_END; end
        PH_END:   if (scan) begin b_r <= stop_khz;  phase <= PH_STEPS; end
        PH_STEPS: if (scan) begin
          lo_o  <= swapped ? b_r : a_r;
          hi_o  <= swapped ? a_r : b_r;
          n_o   <= count_o;
          phase <= PH_DIV;
        end
        PH_DIV:   if (div_done) phase <= PH_RUN;
        default:  phase <= PH_RUN;
      endcase
    end
  end

  assign phase_o = phase;

  // R10: abort always lands in idle
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (rst)
    abort |=> (phase == PH_IDLE));

  // R2: running is entered only from the dividing phase
  assert_run_from_div_R2: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_RUN) && ($past(phase) != PH_RUN)) |-> ($past(phase) == PH_DIV));

  // R2: scan is ignored while running
  assert_run_holds_R2: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_RUN) && !abort) |=> (phase == PH_RUN));

  // R6: stored bounds are ordered
  assert_bounds_order_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN) |-> (lo_o <= hi_o));

endmodule

// File: rtl/sweep_point_gen.sv
module sweep_point_gen #(
  parameter int FW = 18,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          run_go,
  input  logic          in_run,
  input  logic          dwell_tick,
  input  logic [FW-1:0] lo,
  input  logic [FW-1:0] hi,
  input  logic [CW-1:0] n,
  input  logic [FW-1:0] step,
  output logic [FW-1:0] freq_o,
  output logic          load_o,
  output logic          mark_o
);
  logic [CW-1:0] idx;
  logic          last_pt;
  logic          next_last;

  always_comb begin
    last_pt   = (idx == n);
    next_last = ((idx + 1'b1) == n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      freq_o <= '0;
      load_o <= 1'b0;
      mark_o <= 1'b0;
    end else begin
      load_o <= 1'b0;
      mark_o <= 1'b0;
      if (abort) begin
        idx <= idx;
      end else if (run_go) begin
        idx    <= '0;
        freq_o <= lo;
        load_o <= 1'b1;
        mark_o <= 1'b1;
      end else if (in_run && dwell_tick) begin
        load_o <= 1'b1;
        if (last_pt) begin
          idx    <= '0;
          freq_o <= lo;
          mark_o <= 1'b1;
        end else begin
          idx    <= idx + 1'b1;
          freq_o <= next_last ? hi : (freq_o + step);
        end
      end
    end
  end

  // R9: the marker never appears without a load request
  assert_mark_with_load_R9: assert property (@(posedge clk) disable iff (rst)
    mark_o |-> load_o);

  // R9: the marker coincides with the lower bound
  assert_mark_at_lo_R9: assert property (@(posedge clk) disable iff (rst)
    mark_o |-> (freq_o == lo));

  // R5: every loaded point lies within the bounds
  assert_point_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    load_o |-> ((freq_o >= lo) && (freq_o <= hi)));

  // R8: a load follows a tick or the entry into running
  assert_load_cause_R8: assert property (@(posedge clk) disable iff (rst)
    load_o |-> ($past(dwell_tick) || $past(run_go)));

  // R10: no load is issued in the cycle after an abort
  assert_abort_no_load_R10: assert property (@(posedge clk) disable iff (rst)
    abort |=> !load_o);

endmodule

// File: rtl/sweep_scan_ctrl.sv
module sweep_scan_ctrl
  import sweep_pkg::*;
#(
  parameter int FW = 18,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] start_khz,
  input  logic [FW-1:0] stop_khz,
  input  logic [2:0]    steps_sel,
  input  logic          scan,
  input  logic          abort,
  input  logic          dwell_tick,
  output logic [FW-1:0] freq_khz,
  output logic          load_req,
  output logic          sweep_mark,
  output logic [2:0]    phase
);
  phase_e        ph;
  logic          div_go, div_done, run_go;
  logic [FW-1:0] span, lo, hi, step;
  logic [CW-1:0] count, n;

  sweep_phase_fsm #(.FW(FW), .CW(CW)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .scan     (scan),
    .abort    (abort),
    .start_khz(start_khz),
    .stop_khz (stop_khz),
    .steps_sel(steps_sel),
    .div_done (div_done),
    .phase_o  (ph),
    .div_go   (div_go),
    .run_go   (run_go),
    .span_o   (span),
    .count_o  (count),
    .lo_o     (lo),
    .hi_o     (hi),
    .n_o      (n)
  );

  sweep_divider #(.NW(FW), .DW(CW)) u_div (
    .clk     (clk),
    .rst     (rst),
    .go      (div_go),
    .dividend(span),
    .divisor (count),
    .done    (div_done),
    .quotient(step)
  );

  sweep_point_gen #(.FW(FW), .CW(CW)) u_pts (
    .clk       (clk),
    .rst       (rst),
    .abort     (abort),
    .run_go    (run_go),
    .in_run    (ph == PH_RUN),
    .dwell_tick(dwell_tick),
    .lo        (lo),
    .hi        (hi),
    .n         (n),
    .step      (step),
    .freq_o    (freq_khz),
    .load_o    (load_req),
    .mark_o    (sweep_mark)
  );

  assign phase = ph;

endmodule

// File: tb/sweep_scan_ctrl_test.sv
module sweep_scan_ctrl_test;
  localparam int FW = 18;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [FW-1:0] start_khz = '0;
  logic [FW-1:0] stop_khz = '0;
  logic [2:0]    steps_sel = '0;
  logic          scan = 1'b0;
  logic          abort = 1'b0;
  logic          dwell_tick = 1'b0;
  logic [FW-1:0] freq_khz;
  logic          load_req;
  logic          sweep_mark;
  logic [2:0]    phase;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sweep_scan_ctrl #(.FW(FW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .start_khz(start_khz), .stop_khz(stop_khz),
    .steps_sel(steps_sel), .scan(scan), .abort(abort), .dwell_tick(dwell_tick),
    .freq_khz(freq_khz), .load_req(load_req), .sweep_mark(sweep_mark), .phase(phase)
  );

  function automatic int count_of(input int sel);
    if (sel == 0) return 10;
    if (sel == 1) return 20;
    if (sel == 2) return 50;
    if (sel == 3) return 100;
    if (sel == 4) return 200;
    return 500;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, compared on every clock
  int m_ph = 0, m_a = 0, m_b = 0, m_lo = 0, m_hi = 0, m_n = 1, m_step = 0;
  int m_idx = 0, m_freq = 0, m_load = 0, m_mark = 0, m_wait = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_a = 0; m_b = 0; m_freq = 0; m_load = 0; m_mark = 0; m_idx = 0;
    end else begin
      m_load = 0; m_mark = 0;
      if (abort) m_ph = 0;
      else begin
        case (m_ph)
          0: if (scan) m_ph = 1;
          1: if (scan) begin m_a = int'(start_khz); m_ph = 2; end
          2: if (scan) begin m_b = int'(stop_khz); m_ph = 3; end
          3: if (scan) begin
               m_lo = (m_a < m_b) ? m_a : m_b;
               m_hi = (m_a < m_b) ? m_b : m_a;
               m_n = count_of(int'(steps_sel));
               m_step = (m_hi - m_lo) / m_n;
               m_wait = FW;
               m_ph = 4;
             end
          4: if (m_wait == 0) begin
               m_ph = 5; m_idx = 0; m_freq = m_lo; m_load = 1; m_mark = 1;
             end else m_wait--;
          default: if (dwell_tick) begin
               m_load = 1;
               if (m_idx == m_n) begin m_idx = 0; m_freq = m_lo; m_mark = 1; end
               else begin
                 m_idx++;
                 m_freq = (m_idx == m_n) ? m_hi : m_lo + m_idx * m_step;
               end
             end
        endcase
      end
    end
    #2;
    check("R2 phase vs model", int'(phase), m_ph);
    check("R5 freq vs model", int'(freq_khz), m_freq);
    check("R8 load vs model", int'(load_req), m_load);
    check("R9 mark vs model", int'(sweep_mark), m_mark);
  end

  task automatic pulse_scan();
    @(negedge clk) scan = 1'b1;
    @(negedge clk) scan = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk) dwell_tick = 1'b1;
    @(negedge clk) dwell_tick = 1'b0;
  endtask

  task automatic setup(input int s, input int e, input int sel);
    pulse_scan();
    start_khz = FW'(s);
    pulse_scan();
    stop_khz = FW'(e);
    pulse_scan();
    steps_sel = 3'(sel);
    pulse_scan();
  endtask

  task automatic wait_run(output int edges);
    edges = 0;
    while (!load_req && edges < 100) begin
      @(negedge clk);
      edges++;
    end
  endtask

  int edges;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 phase after reset", int'(phase), 0);
    check("R1 freq after reset", int'(freq_khz), 0);
    check("R1 load after reset", int'(load_req), 0);
    check("R1 mark after reset", int'(sweep_mark), 0);

    tick_once();
    check("R8 tick in idle gives no load", int'(load_req), 0);

    // Basic sweep, 10 steps from 1000 to 2000
    setup(1000, 2000, 0);
    check("R2 phase dividing", int'(phase), 4);
    start_khz = FW'(7777);
    stop_khz = FW'(8888);
    wait_run(edges);
    check("R7 divide latency", edges, FW + 1);
    check("R3 first point uses captured start", int'(freq_khz), 1000);
    check("R9 mark on run entry", int'(sweep_mark), 1);
    pulse_scan();
    check("R2 scan ignored while running", int'(phase), 5);
    for (int i = 0; i < 9; i++) tick_once();
    check("R5 ninth point", int'(freq_khz), 1900);
    tick_once();
    check("R5 last point equals stop", int'(freq_khz), 2000);
    check("R9 no mark at stop", int'(sweep_mark), 0);
    tick_once();
    check("R9 wrap to start", int'(freq_khz), 1000);
    check("R9 mark on wrap", int'(sweep_mark), 1);

    pulse_abort();
    check("R10 abort in running", int'(phase), 0);

    // Reversed bounds
    setup(5000, 3000, 0);
    wait_run(edges);
    check("R6 swapped low bound", int'(freq_khz), 3000);
    for (int i = 0; i < 10; i++) tick_once();
    check("R6 swapped high bound", int'(freq_khz), 5000);
    pulse_abort();

    // Span not divisible by the count
    setup(100, 1107, 0);
    wait_run(edges);
    for (int i = 0; i < 9; i++) tick_once();
    check("R5 floor step point", int'(freq_khz), 1000);
    tick_once();
    check("R5 final point exact", int'(freq_khz), 1107);
    pulse_abort();

    // Every step-count choice
    for (int sel = 0; sel < 8; sel++) begin
      int ticks;
      int prev;
      setup(100, 150000, sel);
      wait_run(edges);
      ticks = 0;
      prev = 0;
      do begin
        prev = int'(freq_khz);
        tick_once();
        ticks++;
      end while (!sweep_mark && ticks < 600);
      check("R4 ticks per sweep", ticks, count_of(sel) + 1);
      check("R5 point before wrap is stop", prev, 150000);
      pulse_abort();
    end

    // Abort while dividing
    begin
      int saw_load;
      setup(200, 400, 1);
      repeat (5) @(negedge clk);
      pulse_abort();
      check("R10 abort while dividing", int'(phase), 0);
      saw_load = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (load_req) saw_load = 1;
      end
      check("R10 no load after abort", saw_load, 0);
    end

    // Abort together with a tick while running
    setup(400, 800, 2);
    wait_run(edges);
    tick_once();
    @(negedge clk) begin abort = 1'b1; dwell_tick = 1'b1; end
    @(negedge clk) begin abort = 1'b0; dwell_tick = 1'b0; end
    check("R10 load suppressed", int'(load_req), 0);
    check("R10 phase idle", int'(phase), 0);
    check("R10 freq held", int'(freq_khz), 408);
    tick_once();
    check("R8 tick after abort ignored", int'(load_req), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule